// File: doc/BRIEF.md
# Slave Clock Mode Controller

This block is the supervisory controller of a slave clock fed by up to three timing references. It watches a validity flag for each reference, qualifies each reference through a hold-off timer, picks the most preferred qualified reference from locally programmed priorities, and sequences the clock through free-run, acquiring, locked and holdover modes. It also says which control word steers the oscillator: a fixed nominal word, the live loop word, or a stored holdover word.

The phase detector, loop filter and oscillator sit outside. The loop filter supplies its control word and a lock indication. While locked, the controller keeps a running average of that word. Once lock has lasted long enough, the average counts as valid stored data. When the active reference is lost, this stored data decides between holdover and free-run.

Top module: `clkref_mode_ctrl`

## Requirements
- R1: After reset the outputs are as follows. `mode` is 0 (free-run), `ctrl_src` is 0, `ctrl_word` equals the NOMINAL_WORD parameter, and `ref_active` and `hold_valid` are both 0.
- R2: A reference qualifies only after its `ref_valid` bit has been sampled high on `holdoff_cycles` consecutive clock edges, where a value of 0 acts as 1. Any low sample clears its progress. The mode logic acts on a qualification at the clock edge that follows it.
- R3: The selected reference is the qualified one with the smallest priority value. The priority of reference i is `ref_prio[i*PRIO_W +: PRIO_W]`. On a tie the lowest index wins. `active_ref` reports the index of the selected reference.
- R4: Mode 1 (acquiring) becomes mode 2 (locked) on the edge where `lock_detect` has been sampled high on `acq_cycles` consecutive edges in mode 1, where a value of 0 acts as 1. A low sample restarts the count.
- R5: In mode 1 or mode 2, if a qualified reference is more preferred than the active one, the next edge moves to mode 1 with that reference as the active one. A less preferred reference causes no switch.
- R6: If the active reference stops being qualified in mode 1 or mode 2, the next edge moves to mode 3 (holdover) when `hold_valid` is 1, and to mode 0 otherwise. The decision uses the value `hold_valid` had before that edge.
- R7: The holdover word works as follows. On the first locked cycle after reset it is loaded with `loop_word`. On every later edge taken in mode 2 it becomes avg + floor((loop_word - avg) / 2^AVG_SHIFT). In any other mode it does not change.
- R8: `hold_valid` is set on the edge that completes `qual_cycles` consecutive edges in mode 2, where a value of 0 acts as 1. Once set it stays set until reset.
- R9: `ctrl_src` follows the mode. It is 0 (nominal word) in mode 0, 1 (loop word) in modes 1 and 2, and 2 (stored word) in mode 3. `ctrl_word` carries the word that `ctrl_src` names.
- R10: From mode 0 or mode 3, the edge after any reference qualifies enters mode 1 with the reference selected by R3. In modes 0 and 3, `ref_active` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ref_valid | input | NUM_REFS | Per-reference validity flag |
| ref_prio | input | NUM_REFS*PRIO_W | Packed per-reference priority, lower is preferred |
| holdoff_cycles | input | CNT_W | Edges a reference must stay valid before it qualifies |
| acq_cycles | input | CNT_W | Edges of steady lock indication needed to declare lock |
| qual_cycles | input | CNT_W | Locked edges needed before stored data counts as valid |
| lock_detect | input | 1 | Lock indication from the loop |
| loop_word | input | CW_W | Live control word from the loop filter |
| mode | output | 2 | 0 free-run, 1 acquiring, 2 locked, 3 holdover |
| ref_active | output | 1 | A reference is steering the loop |
| active_ref | output | IDX_W | Index of the selected reference (0 when none) |
| ctrl_src | output | 2 | Oscillator word source: 0 nominal, 1 loop, 2 stored |
| ctrl_word | output | CW_W | Word applied to the oscillator |
| hold_valid | output | 1 | Stored holdover word is qualified |

## Verification
The sharpest coincidence is the loss of the active reference on the same edge that completes holdover qualification. The mode logic must then use the old `hold_valid` and fall to free-run, while `hold_valid` still becomes 1. The bench provokes this by dropping the reference a fixed number of cycles into lock and sweeping `qual_cycles` around that point. It predicts, from the edge arithmetic, which values give holdover, which give free-run with data just qualified, and which give free-run with no data. A second overlap is a more preferred reference qualifying while acquisition is still counting lock samples. The bench judges this from the switch of the active index and the restart of the lock count.

// File: rtl/clkref_mode_pkg.sv
// Package: shared encodings for the slave clock mode controller.
// Assumes a two-bit mode and a two-bit word-source field seen at the ports.
package clkref_mode_pkg;

    typedef enum logic [1:0] {
        MODE_FREE = 2'd0,
        MODE_ACQ  = 2'd1,
        MODE_LOCK = 2'd2,
        MODE_HOLD = 2'd3
    } mode_e;

    typedef enum logic [1:0] {
        SRC_NOMINAL = 2'd0,
        SRC_LOOP    = 2'd1,
        SRC_STORED  = 2'd2
    } src_e;

endpackage

// File: rtl/ref_holdoff.sv
// ref_holdoff: qualifies one reference. The output rises once the validity
// flag has been sampled high on holdoff_cycles consecutive edges (0 acts
// as 1). A single low sample clears the output and the progress count.
// Assumes holdoff_cycles is quasi-static.
module ref_holdoff #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             valid_in,
    input  logic [CNT_W-1:0] holdoff_cycles,
    output logic             qualified
);

    logic [CNT_W-1:0] run_cnt;
    logic [CNT_W:0]   run_next;

    // Count of consecutive valid samples including the current one.
    always_comb run_next = (CNT_W+1)'(run_cnt) + (CNT_W+1)'(1);

    // Hold-off counter and qualification flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_cnt   <= '0;
            qualified <= 1'b0;
        end else if (!valid_in) begin
            run_cnt   <= '0;
            qualified <= 1'b0;
        end else if (!qualified) begin
            run_cnt <= run_next[CNT_W-1:0];
            if (run_next >= (CNT_W+1)'(holdoff_cycles))
                qualified <= 1'b1;
        end
    end

endmodule

// File: rtl/ref_picker.sv
// ref_picker: combinational priority selection among qualified references.
// Lower priority value wins; equal values resolve to the lowest index.
// Assumes priorities are packed with reference i at [i*PRIO_W +: PRIO_W].
module ref_picker #(
    parameter int NUM_REFS = 3,
    parameter int PRIO_W   = 4,
    parameter int IDX_W    = 2
) (
    input  logic [NUM_REFS-1:0]        qual,
    input  logic [NUM_REFS*PRIO_W-1:0] prio,
    output logic                       any_qual,
    output logic [IDX_W-1:0]           best_idx
);

    logic [PRIO_W-1:0] best_prio;

    // Scan upward, replacing the candidate only on a strictly smaller value.
    always_comb begin
        any_qual  = 1'b0;
        best_idx  = '0;
        best_prio = '1;
        for (int i = 0; i < NUM_REFS; i++) begin
            if (qual[i] && (!any_qual || prio[i*PRIO_W +: PRIO_W] < best_prio)) begin
                any_qual  = 1'b1;
                best_prio = prio[i*PRIO_W +: PRIO_W];
                best_idx  = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/holdover_avg.sv
// holdover_avg: keeps the holdover frequency word and its validity.
// The first locked cycle after reset seeds the word. Each later locked edge
// moves it by (loop - avg) arithmetically shifted right by AVG_SHIFT.
// Validity rises after qual_cycles consecutive locked edges and stays set.
module holdover_avg #(
    parameter int CW_W      = 16,
    parameter int CNT_W     = 16,
    parameter int AVG_SHIFT = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_lock,
    input  logic [CW_W-1:0]  loop_word,
    input  logic [CNT_W-1:0] qual_cycles,
    output logic [CW_W-1:0]  avg_word,
    output logic             hold_valid
);

    localparam int EXT_W = CW_W + 2;

    logic                    seeded;
    logic [CNT_W-1:0]        lock_cnt;
    logic [CNT_W:0]          lock_next;
    logic signed [EXT_W-1:0] diff;
    logic signed [EXT_W-1:0] sum;
    logic [CW_W-1:0]         avg_next;

    // Signed step toward the live word; the result stays inside the word range.
    always_comb begin
        diff     = $signed({2'b00, loop_word}) - $signed({2'b00, avg_word});
        sum      = $signed({2'b00, avg_word}) + (diff >>> AVG_SHIFT);
        avg_next = sum[CW_W-1:0];
    end

    // Locked-edge count including the current one.
    always_comb lock_next = (CNT_W+1)'(lock_cnt) + (CNT_W+1)'(1);

    // Running average, updated only while locked.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            avg_word <= '0;
            seeded   <= 1'b0;
        end else if (in_lock) begin
            seeded   <= 1'b1;
            avg_word <= seeded ? avg_next : loop_word;
        end
    end

    // Qualification timer for the stored word; validity is sticky.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lock_cnt   <= '0;
            hold_valid <= 1'b0;
        end else if (!in_lock) begin
            lock_cnt <= '0;
        end else if (!hold_valid) begin
            lock_cnt <= lock_next[CNT_W-1:0];
            if (lock_next >= (CNT_W+1)'(qual_cycles))
                hold_valid <= 1'b1;
        end
    end

endmodule

// File: rtl/mode_seq.sv
// mode_seq: the mode state machine and the active reference register.
// Priority of events in acquiring/locked: loss of the active reference
// first, then a switch to a more preferred reference, then lock counting.
// Assumes qualification flags and the picker result are registered/stable.
module mode_seq
    import clkref_mode_pkg::*;
#(
    parameter int NUM_REFS = 3,
    parameter int IDX_W    = 2,
    parameter int CNT_W    = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_REFS-1:0] qual,
    input  logic                any_qual,
    input  logic [IDX_W-1:0]    best_idx,
    input  logic                lock_detect,
    input  logic [CNT_W-1:0]    acq_cycles,
    input  logic                hold_valid,
    output mode_e               mode,
    output logic [IDX_W-1:0]    sel
);

    localparam int EXT_N = 1 << IDX_W;

    logic [EXT_N-1:0] qual_ext;
    logic             sel_ok;
    logic [CNT_W-1:0] acq_cnt;
    logic [CNT_W:0]   acq_next;
    mode_e            lost_mode;

    // Zero-extend so every selector value indexes a defined bit.
    always_comb qual_ext = EXT_N'(qual);

    // Whether the active reference is still qualified.
    always_comb sel_ok = qual_ext[sel];

    // Consecutive lock samples including the current one.
    always_comb acq_next = (CNT_W+1)'(acq_cnt) + (CNT_W+1)'(1);

    // Destination on loss of the active reference.
    always_comb lost_mode = hold_valid ? MODE_HOLD : MODE_FREE;

    // Mode transitions, selection and acquisition counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode    <= MODE_FREE;
            sel     <= '0;
            acq_cnt <= '0;
        end else begin
            unique case (mode)
                MODE_FREE, MODE_HOLD: begin
                    acq_cnt <= '0;
                    if (any_qual) begin
                        mode <= MODE_ACQ;
                        sel  <= best_idx;
                    end
                end
                MODE_ACQ: begin
                    if (!sel_ok) begin
                        mode    <= lost_mode;
                        acq_cnt <= '0;
                    end else if (best_idx != sel) begin
                        sel     <= best_idx;
                        acq_cnt <= '0;
                    end else if (!lock_detect) begin
                        acq_cnt <= '0;
                    end else if (acq_next >= (CNT_W+1)'(acq_cycles)) begin
                        mode    <= MODE_LOCK;
                        acq_cnt <= '0;
                    end else begin
                        acq_cnt <= acq_next[CNT_W-1:0];
                    end
                end
                MODE_LOCK: begin
                    acq_cnt <= '0;
                    if (!sel_ok) begin
                        mode <= lost_mode;
                    end else if (best_idx != sel) begin
                        mode <= MODE_ACQ;
                        sel  <= best_idx;
                    end
                end
                default: mode <= MODE_FREE;
            endcase
        end
    end

endmodule

// File: rtl/clkref_mode_ctrl.sv
// clkref_mode_ctrl: top of the slave clock mode controller. It qualifies
// each reference, picks the preferred one, sequences the modes and selects
// the word that steers the oscillator. Assumes all inputs are synchronous
// to clk; the timer limits may change only while the block is idle.
module clkref_mode_ctrl
    import clkref_mode_pkg::*;
#(
    parameter int NUM_REFS       = 3,
    parameter int PRIO_W         = 4,
    parameter int CW_W           = 16,
    parameter int CNT_W          = 16,
    parameter int AVG_SHIFT      = 3,
    parameter logic [CW_W-1:0] NOMINAL_WORD = CW_W'(1) << (CW_W - 1),
    localparam int IDX_W         = (NUM_REFS > 1) ? $clog2(NUM_REFS) : 1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NUM_REFS-1:0]        ref_valid,
    input  logic [NUM_REFS*PRIO_W-1:0] ref_prio,
    input  logic [CNT_W-1:0]           holdoff_cycles,
    input  logic [CNT_W-1:0]           acq_cycles,
    input  logic [CNT_W-1:0]           qual_cycles,
    input  logic                       lock_detect,
    input  logic [CW_W-1:0]            loop_word,
    output logic [1:0]                 mode,
    output logic                       ref_active,
    output logic [IDX_W-1:0]           active_ref,
    output logic [1:0]                 ctrl_src,
    output logic [CW_W-1:0]            ctrl_word,
    output logic                       hold_valid
);

    logic [NUM_REFS-1:0] ref_qual;
    logic                any_qual;
    logic [IDX_W-1:0]    best_idx;
    logic [IDX_W-1:0]    sel;
    logic [CW_W-1:0]     avg_word;
    mode_e               cur_mode;
    src_e                src;

    // One hold-off qualifier per reference input.
    for (genvar g = 0; g < NUM_REFS; g++) begin : g_ref
        ref_holdoff #(.CNT_W(CNT_W)) u_holdoff (
            .clk            (clk),
            .rst_n          (rst_n),
            .valid_in       (ref_valid[g]),
            .holdoff_cycles (holdoff_cycles),
            .qualified      (ref_qual[g])
        );
    end

    ref_picker #(.NUM_REFS(NUM_REFS), .PRIO_W(PRIO_W), .IDX_W(IDX_W)) u_picker (
        .qual     (ref_qual),
        .prio     (ref_prio),
        .any_qual (any_qual),
        .best_idx (best_idx)
    );

    mode_seq #(.NUM_REFS(NUM_REFS), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .qual        (ref_qual),
        .any_qual    (any_qual),
        .best_idx    (best_idx),
        .lock_detect (lock_detect),
        .acq_cycles  (acq_cycles),
        .hold_valid  (hold_valid),
        .mode        (cur_mode),
        .sel         (sel)
    );

    holdover_avg #(.CW_W(CW_W), .CNT_W(CNT_W), .AVG_SHIFT(AVG_SHIFT)) u_store (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_lock     (cur_mode == MODE_LOCK),
        .loop_word   (loop_word),
        .qual_cycles (qual_cycles),
        .avg_word    (avg_word),
        .hold_valid  (hold_valid)
    );

    // Oscillator word source chosen from the mode.
    always_comb begin
        unique case (cur_mode)
            MODE_ACQ, MODE_LOCK: src = SRC_LOOP;
            MODE_HOLD:           src = SRC_STORED;
            default:             src = SRC_NOMINAL;
        endcase
    end

    // Word multiplexer and port-side status.
    always_comb begin
        unique case (src)
            SRC_LOOP:   ctrl_word = loop_word;
            SRC_STORED: ctrl_word = avg_word;
            default:    ctrl_word = NOMINAL_WORD;
        endcase
        ctrl_src   = src;
        mode       = cur_mode;
        ref_active = (cur_mode == MODE_ACQ) || (cur_mode == MODE_LOCK);
        active_ref = ref_active ? sel : '0;
    end

endmodule

// File: rtl/clkref_mode_ctrl_chk.sv
// clkref_mode_ctrl_chk: temporal checks on the mode controller ports,
// attached to every instance of the top by the bind below.
module clkref_mode_ctrl_chk #(
    parameter int CW_W = 16
) (
    input logic            clk,
    input logic            rst_n,
    input logic            lock_detect,
    input logic [1:0]      mode,
    input logic            hold_valid,
    input logic [CW_W-1:0] ctrl_word
);

    // R6: holdover is only ever entered with qualified stored data.
    a_r6_hold_has_data: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'd3) |-> hold_valid);

    // R8: stored-data validity never drops outside reset.
    a_r8_valid_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        hold_valid |=> hold_valid);

    // R4: lock is reached only from acquiring with the lock indication high.
    a_r4_lock_from_acq: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'd2 && $past(mode) != 2'd2) |-> ($past(mode) == 2'd1 && $past(lock_detect)));

    // R10: free-run can only be left for acquiring.
    a_r10_free_exit: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(mode) == 2'd0 && mode != 2'd0) |-> (mode == 2'd1));

    // R7: the stored word is frozen while holdover persists.
    a_r7_hold_word_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'd3 && $past(mode) == 2'd3) |-> $stable(ctrl_word));

endmodule

bind clkref_mode_ctrl clkref_mode_ctrl_chk #(.CW_W(CW_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .lock_detect (lock_detect),
    .mode        (mode),
    .hold_valid  (hold_valid),
    .ctrl_word   (ctrl_word)
);

// File: tb/sim_clkref_mode_ctrl.sv
module sim_clkref_mode_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int NREF  = 3;
    localparam int PW    = 4;
    localparam int CW    = 16;
    localparam int CW_N  = 8;
    localparam int SHIFT = 3;
    localparam logic [CW-1:0] NOMINAL = 16'h8000;

    logic             clk = 1'b0;
    logic             rst_n;
    logic [NREF-1:0]  ref_valid;
    logic [NREF*PW-1:0] ref_prio;
    logic [CW_N-1:0]  holdoff_cycles, acq_cycles, qual_cycles;
    logic             lock_detect;
    logic [CW-1:0]    loop_word;
    logic [1:0]       mode;
    logic             ref_active;
    logic [1:0]       active_ref;
    logic [1:0]       ctrl_src;
    logic [CW-1:0]    ctrl_word;
    logic             hold_valid;

    int tests = 0;
    int fails = 0;
    int model_avg = 0;
    bit model_seeded = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    clkref_mode_ctrl #(
        .NUM_REFS(NREF), .PRIO_W(PW), .CW_W(CW), .CNT_W(CW_N),
        .AVG_SHIFT(SHIFT), .NOMINAL_WORD(NOMINAL)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .ref_valid(ref_valid), .ref_prio(ref_prio),
        .holdoff_cycles(holdoff_cycles), .acq_cycles(acq_cycles),
        .qual_cycles(qual_cycles), .lock_detect(lock_detect),
        .loop_word(loop_word), .mode(mode), .ref_active(ref_active),
        .active_ref(active_ref), .ctrl_src(ctrl_src), .ctrl_word(ctrl_word),
        .hold_valid(hold_valid)
    );

    task automatic chk(input string req, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // One clock edge; the averaging model follows R7 using the pre-edge mode.
    task automatic tick();
        if (mode == 2'd2) begin
            if (!model_seeded) begin
                model_avg    = int'(loop_word);
                model_seeded = 1;
            end else begin
                model_avg = model_avg + ((int'(loop_word) - model_avg) >>> SHIFT);
            end
        end
        @(posedge clk);
        #1;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        ref_valid = '0;
        ref_prio = '0;
        holdoff_cycles = 8'd1;
        acq_cycles = 8'd1;
        qual_cycles = 8'd100;
        lock_detect = 1'b1;
        loop_word = 16'h4000;
        model_seeded = 0;
        model_avg = 0;
        @(posedge clk); #1;
        @(posedge clk); #1;
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        // R1 / R9: reset state
        do_reset();
        chk("R1 mode", mode, 0);
        chk("R1 ctrl_src", ctrl_src, 0);
        chk("R1 ctrl_word", ctrl_word, NOMINAL);
        chk("R1 ref_active", ref_active, 0);
        chk("R1 hold_valid", hold_valid, 0);

        // R2 / R4 / R9: sweep hold-off and acquisition lengths
        for (int h = 1; h <= 3; h++) begin
            for (int a = 1; a <= 3; a++) begin
                do_reset();
                holdoff_cycles = 8'(h);
                acq_cycles = 8'(a);
                ref_valid = 3'b001;
                ticks(h);
                chk("R2 still free at qualification edge", mode, 0);
                tick();
                chk("R2 acquiring after hold-off", mode, 1);
                chk("R9 loop word in acquiring", ctrl_word, 16'h4000);
                if (a > 1) begin
                    ticks(a - 1);
                    chk("R4 not yet locked", mode, 1);
                end
                tick();
                chk("R4 locked after acq_cycles", mode, 2);
                chk("R9 loop source in lock", ctrl_src, 1);
            end
        end

        // R2: a short validity glitch restarts the hold-off
        do_reset();
        holdoff_cycles = 8'd3;
        ref_valid = 3'b001;
        ticks(2);
        ref_valid = 3'b000;
        tick();
        ref_valid = 3'b001;
        ticks(2);
        chk("R2 glitch restarted hold-off", mode, 0);
        tick();
        chk("R2 requalified only after full hold-off", mode, 0);
        tick();
        chk("R2 acquiring after restart", mode, 1);

        // R4: a low lock sample restarts the count
        do_reset();
        acq_cycles = 8'd3;
        ref_valid = 3'b001;
        ticks(2);
        chk("R4 entered acquiring", mode, 1);
        ticks(2);
        lock_detect = 1'b0;
        tick();
        lock_detect = 1'b1;
        ticks(2);
        chk("R4 count restarted by low sample", mode, 1);
        tick();
        chk("R4 locked after three fresh samples", mode, 2);

        // R3: all priority combinations with every reference valid
        for (int p0 = 0; p0 < 3; p0++)
            for (int p1 = 0; p1 < 3; p1++)
                for (int p2 = 0; p2 < 3; p2++) begin
                    int bi;
                    int bp;
                    do_reset();
                    ref_prio = {4'(p2), 4'(p1), 4'(p0)};
                    ref_valid = 3'b111;
                    bi = 0; bp = p0;
                    if (p1 < bp) begin bi = 1; bp = p1; end
                    if (p2 < bp) begin bi = 2; bp = p2; end
                    ticks(2);
                    chk("R3 selected index", active_ref, bi);
                end

        // R5: switch to a more preferred reference after its hold-off
        do_reset();
        ref_prio = {4'd5, 4'd3, 4'd1};
        holdoff_cycles = 8'd4;
        ref_valid = 3'b010;
        ticks(6);
        chk("R5 locked on ref 1", mode, 2);
        chk("R5 active ref 1", active_ref, 1);
        ref_valid = 3'b011;
        ticks(4);
        chk("R5 no switch before hold-off", active_ref, 1);
        chk("R5 still locked before hold-off", mode, 2);
        tick();
        chk("R5 reacquiring after switch", mode, 1);
        chk("R5 switched to ref 0", active_ref, 0);
        tick();
        ref_valid = 3'b111;
        ticks(6);
        chk("R5 less preferred ref ignored", active_ref, 0);
        chk("R5 lock kept", mode, 2);

        // R7 / R8 / R6 / R9 / R10: holdover capture and re-acquisition
        do_reset();
        qual_cycles = 8'd4;
        ref_valid = 3'b001;
        loop_word = 16'h1000;
        ticks(3);
        chk("R8 locked before qualification", mode, 2);
        for (int k = 0; k < 3; k++) begin
            loop_word = 16'(16'h1000 + 16'((k * 397) % 977));
            tick();
        end
        chk("R8 not valid after three locked edges", hold_valid, 0);
        loop_word = 16'h1555;
        tick();
        chk("R8 valid after four locked edges", hold_valid, 1);
        for (int k = 0; k < 6; k++) begin
            loop_word = 16'(16'h0800 + 16'((k * 1231) % 4099));
            tick();
        end
        ref_valid = 3'b000;
        loop_word = 16'h3abc;
        tick();
        loop_word = 16'h0123;
        tick();
        chk("R6 holdover with stored data", mode, 3);
        chk("R9 stored source", ctrl_src, 2);
        chk("R7 stored word", ctrl_word, model_avg);
        chk("R10 no active ref in holdover", ref_active, 0);
        loop_word = 16'hffff;
        ticks(3);
        chk("R7 stored word frozen in holdover", ctrl_word, model_avg);
        ref_valid = 3'b001;
        tick();
        tick();
        chk("R10 holdover to acquiring", mode, 1);
        tick();
        chk("R10 relocked", mode, 2);
        chk("R8 validity kept", hold_valid, 1);

        // R6 / R8: loss collides with qualification completion
        for (int q = 2; q <= 5; q++) begin
            do_reset();
            qual_cycles = 8'(q);
            ref_valid = 3'b001;
            ticks(3);
            ticks(2);
            ref_valid = 3'b000;
            ticks(2);
            chk("R6 mode after loss", mode, (q <= 3) ? 3 : 0);
            chk("R8 validity after loss", hold_valid, (q <= 4) ? 1 : 0);
        end

        // R6: loss during acquisition with no stored data
        do_reset();
        acq_cycles = 8'd5;
        ref_valid = 3'b001;
        ticks(2);
        ref_valid = 3'b000;
        ticks(2);
        chk("R6 free-run without data", mode, 0);
        chk("R9 nominal word", ctrl_word, NOMINAL);

        finished = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule